// File: doc/BRIEF.md
# Acquisition Run Sequencer

This block controls one acquisition run for a four-channel sampling block. Software first arms it, which also stores the run settings. While armed it waits for a start event. The event is either a software trigger pulse or an edge on an asynchronous external trigger line, and software chooses the edge direction. After the start event the block waits a programmable delay counted in whole microseconds. It then passes sample strobes through as memory write enables until the programmed number of bytes has been written or software aborts the run.

The design has five states, and only one of them is active at a time:
- IDLE is the state after reset.
- ARMED waits for a start event.
- DELAY counts the post-trigger wait.
- ACQ passes writes through.
- DONE holds until the next arm command.

The transitions are:
- arm: IDLE→ARMED and DONE→ARMED.
- start: ARMED→DELAY, or ARMED→ACQ when the delay is zero.
- expire: DELAY→ACQ.
- fill: ACQ→DONE.
- abort: ARMED→IDLE, DELAY→IDLE and ACQ→DONE.

Each state drives one status flag, except IDLE, which drives none. The sample memory and the converters are outside this block.

Top module: `acq_run_ctrl`

## Requirements
- R1: After reset the block is in IDLE: st_armed, st_delaying, st_acquiring, st_done and wr_en are all 0.
- R2: An arm_cmd pulse in IDLE or DONE moves the block to ARMED at the next clock edge. arm_cmd has no effect in ARMED, DELAY or ACQ.
- R3: With trig_src_hw=0, an sw_trig pulse in ARMED is the start event. With trig_src_hw=1, sw_trig has no effect.
- R4: With trig_src_hw=1, ext_trig passes through two synchronizing flops before its edge is detected. trig_pol_fall=0 selects the 0→1 edge and trig_pol_fall=1 selects the 1→0 edge. The block leaves ARMED at the third rising clock edge after ext_trig changes.
- R5: Start events that arrive in IDLE, DELAY, ACQ or DONE are ignored.
- R6: When the captured delay D is nonzero, a start event moves the block to DELAY. It stays there for exactly D×CLK_PER_US cycles and then enters ACQ. When D=0, the start event moves the block straight to ACQ.
- R7: wr_en = st_acquiring AND sample_vld AND NOT abort_cmd. Each wr_en cycle counts BEAT_BYTES (default 8) bytes.
- R8: When the byte total reaches or passes the captured size S, the block enters DONE on the next edge. A run therefore has exactly ceil(S/BEAT_BYTES) write cycles; S of 4 bytes or less gives one write cycle.
- R9: abort_cmd in ACQ moves the block to DONE, and wr_en is already low in the abort cycle. abort_cmd in ARMED or DELAY moves the block to IDLE.
- R10: At most one status flag is high at a time. st_done stays high until an arm_cmd arrives.
- R11: delay_us and size_bytes are captured when an arm command is accepted. Changing them later has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_cmd | input | 1 | Arm pulse from software |
| abort_cmd | input | 1 | Software abort / disable |
| sw_trig | input | 1 | Software start pulse |
| trig_src_hw | input | 1 | 1 = external trigger is the start source |
| trig_pol_fall | input | 1 | 1 = falling edge of the external trigger |
| ext_trig | input | 1 | Asynchronous external trigger line |
| delay_us | input | 32 | Post-trigger delay in microseconds |
| size_bytes | input | 32 | Run length in bytes |
| sample_vld | input | 1 | Sample strobe from the converter side |
| wr_en | output | 1 | Memory write enable |
| st_armed | output | 1 | State is ARMED |
| st_delaying | output | 1 | State is DELAY |
| st_acquiring | output | 1 | State is ACQ |
| st_done | output | 1 | State is DONE |

## Verification
The bench targets the following corner cases:
- Exact length of the microsecond wait: a prescaler that restarts late or counts one tick too many shifts the moment ACQ starts, and the per-cycle comparison catches that shift.
- A byte size that is not a multiple of the beat width, and the minimum size: a counter that compares with > instead of ≥ writes one beat too many.
- Sample strobes with gaps: a counter that counts cycles instead of strobes ends early.
- Triggers in the wrong state, a trigger from the unselected source, and the falling-edge polarity: a design that latches stray edges would start on its own.
- The exact trigger latency: a missing synchronizer stage would make the trigger one cycle early.
- A settings change after arming: a design that reads the live inputs would change the run length.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ARMED = 3'd1,
        S_DELAY = 3'd2,
        S_ACQ   = 3'd3,
        S_DONE  = 3'd4
    } acq_state_t;
endpackage

// File: rtl/acq_trig_front.sv
// Start-event front end: synchronizer chain, edge detect, source select.
module acq_trig_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_trig,
    input  logic pol_fall,
    input  logic src_hw,
    input  logic sw_trig,
    output logic start_evt
);
    // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds previous value
    logic [SYNC_STAGES:0] chain;
    logic                 now_lvl;
    logic                 old_lvl;
    logic                 hw_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= ext_trig;
    end

    for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign now_lvl = chain[SYNC_STAGES-1];
    assign old_lvl = chain[SYNC_STAGES];

    always_comb begin
        if (pol_fall) hw_evt = old_lvl & ~now_lvl;
        else          hw_evt = now_lvl & ~old_lvl;
    end

    assign start_evt = src_hw ? hw_evt : sw_trig;
endmodule

// File: rtl/acq_delay_timer.sv
// Microsecond prescaler plus microsecond counter; expire pulses on the last cycle.
module acq_delay_timer #(
    parameter int CLK_PER_US = 200,
    parameter int DELAY_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [DELAY_W-1:0] delay_us,
    output logic               expire
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0]      pre_q;
    logic [DELAY_W-1:0] us_q;
    logic               us_tick;

    assign us_tick = run && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pre_q <= '0;
        else if (us_tick)    pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) us_q <= '0;
        else if (us_tick)   us_q <= us_q + 1'b1;
    end

    assign expire = us_tick && (us_q == delay_us - 1'b1);

    // R6: the timer never fires while it is stopped
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !expire);
    // R6: after a stop the prescaler restarts from zero
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/acq_beat_count.sv
// Byte accumulator for one run; last is high on the beat that fills the size.
module acq_beat_count #(
    parameter int SIZE_W     = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [SIZE_W-1:0] limit,
    output logic              last
);
    localparam int AW = SIZE_W + 1;
    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    logic [AW-1:0] bytes_q;
    logic [AW-1:0] bytes_nx;

    assign bytes_nx = bytes_q + STEP;
    assign last     = inc && (bytes_nx >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) bytes_q <= '0;
        else if (inc)      bytes_q <= bytes_nx;
    end

    // R8: the total stays below the limit while the run is still open
    below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (limit != '0)) |-> (bytes_q < {1'b0, limit}));
endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl #(
    parameter int CLK_PER_US  = 200,
    parameter int BEAT_BYTES  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_W     = 32,
    parameter int SIZE_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_cmd,
    input  logic               abort_cmd,
    input  logic               sw_trig,
    input  logic               trig_src_hw,
    input  logic               trig_pol_fall,
    input  logic               ext_trig,
    input  logic [DELAY_W-1:0] delay_us,
    input  logic [SIZE_W-1:0]  size_bytes,
    input  logic               sample_vld,
    output logic               wr_en,
    output logic               st_armed,
    output logic               st_delaying,
    output logic               st_acquiring,
    output logic               st_done
);
    import acq_pkg::*;

    acq_state_t         state_q;
    acq_state_t         state_d;
    logic [DELAY_W-1:0] cfg_delay_q;
    logic [SIZE_W-1:0]  cfg_size_q;
    logic               cfg_load;
    logic               start_evt;
    logic               dly_expire;
    logic               fill_last;
    logic               beat;

    acq_trig_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_trig  (ext_trig),
        .pol_fall  (trig_pol_fall),
        .src_hw    (trig_src_hw),
        .sw_trig   (sw_trig),
        .start_evt (start_evt)
    );

    acq_delay_timer #(.CLK_PER_US(CLK_PER_US), .DELAY_W(DELAY_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == S_DELAY),
        .delay_us (cfg_delay_q),
        .expire   (dly_expire)
    );

    acq_beat_count #(.SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) i_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_ACQ),
        .inc   (beat),
        .limit (cfg_size_q),
        .last  (fill_last)
    );

    assign cfg_load = arm_cmd && ((state_q == S_IDLE) || (state_q == S_DONE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_delay_q <= '0;
            cfg_size_q  <= '0;
        end else if (cfg_load) begin
            cfg_delay_q <= delay_us;
            cfg_size_q  <= size_bytes;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (arm_cmd) state_d = S_ARMED;
            S_ARMED: begin
                if (abort_cmd)      state_d = S_IDLE;
                else if (start_evt) state_d = (cfg_delay_q == '0) ? S_ACQ : S_DELAY;
            end
            S_DELAY: begin
                if (abort_cmd)       state_d = S_IDLE;
                else if (dly_expire) state_d = S_ACQ;
            end
            S_ACQ:   if (abort_cmd || fill_last) state_d = S_DONE;
            S_DONE:  if (arm_cmd) state_d = S_ARMED;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        st_armed     = 1'b0;
        st_delaying  = 1'b0;
        st_acquiring = 1'b0;
        st_done      = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_ARMED: st_armed     = 1'b1;
            S_DELAY: st_delaying  = 1'b1;
            S_ACQ:   st_acquiring = 1'b1;
            S_DONE:  st_done      = 1'b1;
            default: ;
        endcase
        beat  = st_acquiring && sample_vld && !abort_cmd;
        wr_en = beat;
    end

    // R10
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_armed, st_delaying, st_acquiring, st_done}));
    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !arm_cmd) |=> st_done);
    // R2
    arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && arm_cmd) |=> st_armed);
    // R9
    abort_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_acquiring && abort_cmd) |=> st_done);
    // R7
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sample_vld && !abort_cmd));
    // R5
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !arm_cmd) |=> (state_q == S_IDLE));
endmodule

// File: tb/test_acq_run_ctrl.sv
`timescale 1ns/100ps
module test_acq_run_ctrl;
    localparam int NUS = 200;
    localparam int BB  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_cmd = 0, abort_cmd = 0, sw_trig = 0, trig_src_hw = 0, trig_pol_fall = 0, ext_trig = 0;
    logic [31:0] delay_us = 0, size_bytes = 0;
    int   vld_mode = 0;
    logic ph = 1'b0;
    logic sample_vld;
    logic wr_en, st_armed, st_delaying, st_acquiring, st_done;

    always #2.5 clk = ~clk;

    assign sample_vld = (vld_mode == 0) ? 1'b1 : (vld_mode == 1) ? ph : 1'b0;
    always @(posedge clk) begin #1; ph <= ~ph; end

    acq_run_ctrl i_acq_run_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_cmd(arm_cmd), .abort_cmd(abort_cmd),
        .sw_trig(sw_trig), .trig_src_hw(trig_src_hw), .trig_pol_fall(trig_pol_fall),
        .ext_trig(ext_trig), .delay_us(delay_us), .size_bytes(size_bytes),
        .sample_vld(sample_vld), .wr_en(wr_en), .st_armed(st_armed),
        .st_delaying(st_delaying), .st_acquiring(st_acquiring), .st_done(st_done)
    );

    // Behavioural reference: mode 0 idle, 1 armed, 2 waiting, 3 writing, 4 finished
    int          m_mode = 0;
    longint      m_left = 0, m_bytes = 0, m_cd = 0, m_cs = 0;
    logic        q_ext[$] = '{1'b0, 1'b0, 1'b0};
    string       req_tag = "R1";
    int          cmp_a = 0, bad_a = 0, cmp_b = 0, bad_b = 0, beats = 0;

    always @(posedge clk) begin
        logic now_v, old_v, hw, st, wr;
        now_v = q_ext[1]; old_v = q_ext[2];
        hw = trig_pol_fall ? (old_v && !now_v) : (now_v && !old_v);
        st = trig_src_hw ? hw : sw_trig;
        wr = (m_mode == 3) && sample_vld && !abort_cmd;
        if (!rst_n) begin
            m_mode = 0; q_ext = '{1'b0, 1'b0, 1'b0};
            m_cd = 0; m_cs = 0;
        end else begin
            case (m_mode)
                0: if (arm_cmd) begin m_mode = 1; m_cd = delay_us; m_cs = size_bytes; end
                1: if (abort_cmd) m_mode = 0;
                   else if (st) begin
                       if (m_cd == 0) begin m_mode = 3; m_bytes = 0; end
                       else begin m_mode = 2; m_left = m_cd * NUS; end
                   end
                2: if (abort_cmd) m_mode = 0;
                   else begin
                       m_left--;
                       if (m_left == 0) begin m_mode = 3; m_bytes = 0; end
                   end
                3: if (abort_cmd) m_mode = 4;
                   else if (wr) begin
                       m_bytes += BB;
                       if (m_bytes >= m_cs) m_mode = 4;
                   end
                4: if (arm_cmd) begin m_mode = 1; m_cd = delay_us; m_cs = size_bytes; end
                default: m_mode = 0;
            endcase
            q_ext.push_front(ext_trig);
            void'(q_ext.pop_back());
        end
    end

    always @(negedge clk) begin
        logic [4:0] exp_v, got_v;
        exp_v = {m_mode == 1, m_mode == 2, m_mode == 3, m_mode == 4,
                 (m_mode == 3) && sample_vld && !abort_cmd};
        got_v = {st_armed, st_delaying, st_acquiring, st_done, wr_en};
        if (rst_n) begin
            cmp_a++;
            if (got_v !== exp_v) begin
                bad_a++;
                $display("FAIL %s t=%0t flags{arm,dly,acq,done,wr} actual=%b expected=%b",
                         req_tag, $time, got_v, exp_v);
            end
            if (wr_en) beats++;
        end
    end

    task automatic chk(input string r, input longint act, input longint exp);
        cmp_b++;
        if (act != exp) begin
            bad_b++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_arm();   arm_cmd = 1;   step(1); arm_cmd = 0;   endtask
    task automatic pulse_trig();  sw_trig = 1;   step(1); sw_trig = 0;   endtask
    task automatic pulse_abort(); abort_cmd = 1; step(1); abort_cmd = 0; endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !st_done; i++) step(1);
    endtask

    task automatic summary(input int extra);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 cmp_a + cmp_b + extra, bad_a + bad_b + extra);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        summary(1);
        $finish;
    end

    initial begin
        int b0, n;
        step(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {st_armed, st_delaying, st_acquiring, st_done, wr_en}, 0);
        step(1);

        // R5 triggers in IDLE ignored
        req_tag = "R5";
        pulse_trig(); ext_trig = 1; step(6); ext_trig = 0; step(6);
        chk("R5", {st_armed, st_delaying, st_acquiring, st_done}, 0);

        // R3/R8 software start, no delay, size 32 -> 4 beats
        req_tag = "R8";
        delay_us = 0; size_bytes = 32; vld_mode = 0;
        pulse_arm();
        chk("R2", st_armed, 1);
        b0 = beats;
        pulse_trig();
        chk("R3", st_acquiring, 1);
        wait_done(100); step(2);
        chk("R8", beats - b0, 4);

        // R10 done holds; R6 1 us delay; R8 size 20 with gapped strobes -> 3 beats
        req_tag = "R6";
        step(10);
        chk("R10", st_done, 1);
        delay_us = 1; size_bytes = 20; vld_mode = 1;
        pulse_arm();
        pulse_trig();
        n = 0;
        while (st_delaying && n < 1000) begin
            if (n == 5) begin sw_trig = 1; arm_cmd = 1; end  // R5/R2: ignored in DELAY
            if (n == 6) begin sw_trig = 0; arm_cmd = 0; end
            step(1); n++;
        end
        chk("R6", n, NUS);
        b0 = beats;
        arm_cmd = 1; step(1); arm_cmd = 0;  // R2 ignored in ACQ
        req_tag = "R7";
        wait_done(200); step(2);
        chk("R7", beats - b0, 3);

        // R4 rising external edge, delay 0, size 4 -> 1 beat; R3 sw ignored
        req_tag = "R4";
        trig_src_hw = 1; trig_pol_fall = 0; delay_us = 0; size_bytes = 4; vld_mode = 0;
        pulse_arm();
        pulse_trig(); step(3);
        chk("R3", st_armed, 1);
        b0 = beats;
        ext_trig = 1;
        step(2);
        chk("R4", st_armed, 1);
        step(1);
        chk("R4", st_acquiring, 1);
        wait_done(50); step(2);
        chk("R8", beats - b0, 1);

        // R4 falling edge, R11 size change after arm, R6 2 us, R9 abort in ACQ
        req_tag = "R11";
        trig_pol_fall = 1; delay_us = 2; size_bytes = 64;
        step(5);
        pulse_arm();
        size_bytes = 8; delay_us = 0;
        step(3);
        b0 = beats;
        ext_trig = 0;
        step(4);
        chk("R11", st_delaying, 1);
        for (int i = 0; i < 2000 && !st_acquiring; i++) step(1);
        step(5);
        chk("R11", st_acquiring, 1);
        req_tag = "R9";
        pulse_abort();
        chk("R9", st_done, 1);
        chk("R9", beats - b0, 5);

        // R9 abort in DELAY returns to IDLE
        trig_src_hw = 0; delay_us = 1; size_bytes = 16;
        pulse_arm(); pulse_trig(); step(40);
        chk("R9", st_delaying, 1);
        pulse_abort();
        chk("R9", {st_armed, st_delaying, st_acquiring, st_done}, 0);
        step(300);
        chk("R5", {st_armed, st_delaying, st_acquiring, st_done, wr_en}, 0);

        summary(0);
        $finish;
    end
endmodule